// File: doc/BRIEF.md
# Last-Changed-Input Indicator

This block watches two asynchronous level inputs and reports which of them toggled most recently. Output `z1_o` is high while the latest toggle came from `x1_i`, and `z2_o` is high while it came from `x2_i`. The outputs record history and do not follow the current input levels. A rising edge and a falling edge count the same, and the flagged output stays high until a different input toggles.

The design is a clocked equivalent of a fundamental-mode machine. Each input first passes through a two-flop synchroniser. A reference register holds the previous synchronised value, and comparing against it gives a per-input change vector. A small tracker register then keeps the one-hot identity of the last single-input change. A cycle in which both inputs change at once falls outside fundamental mode, so it is ignored.

Top module: `last_change_ind`

## Requirements
- R1: A change applied to one input just before rising edge k reaches the outputs at rising edge k+2 (two synchroniser flops, then the output register). Before that edge the outputs keep their previous value.
- R2: When the last change seen was on `x1_i` alone, in either direction, the outputs are `z1_o`=1 and `z2_o`=0.
- R3: When the last change seen was on `x2_i` alone, in either direction, the outputs are `z2_o`=1 and `z1_o`=0.
- R4: `z1_o` and `z2_o` are never high together.
- R5: While neither synchronised input changes, both outputs hold their value for any number of cycles.
- R6: If both synchronised inputs change in the same cycle, the outputs keep their previous value.
- R7: Asserting `rst_ni` low clears both outputs at once. After release they stay 0 until a change is seen. The synchroniser and reference registers reset low, so an input that is high at release counts as a rising change on that input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| x1_i | input | 1 | First level input, asynchronous |
| x2_i | input | 1 | Second level input, asynchronous |
| z1_o | output | 1 | High while `x1_i` was the last input to change |
| z2_o | output | 1 | High while `x2_i` was the last input to change |

## Verification
Every result falls due on the third rising edge after an input is driven, counting the edge the drive was set up for. The bench drives inputs on falling edges. It samples 1 ns after the second rising edge, where the old value must still hold, and 1 ns after the third, where the new value must appear. The bench sweeps every transition between all four input pairs, including both inputs flipping together. It also releases reset with an input already high and runs a long quiet stretch, and it uses the same three-edge count for each of these.

// File: rtl/lci_pkg.sv
package lci_pkg;
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ONE  = 2'd1,
    EV_MANY = 2'd2
  } chg_ev_e;
endpackage

// File: rtl/lci_sync.sv
module lci_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lci_change_det.sv
module lci_change_det
  import lci_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  output logic [WIDTH-1:0] chg_o,
  output chg_ev_e          ev_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] ref_q;
  logic [CNT_W-1:0] n_chg;

  // reference resets low: a high input at release reads as a rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= '0;
    else         ref_q <= sync_i;
  end

  assign chg_o = sync_i ^ ref_q;

  always_comb begin
    n_chg = '0;
    for (int i = 0; i < WIDTH; i++) n_chg = n_chg + CNT_W'(chg_o[i]);
  end

  always_comb begin
    if (n_chg == '0)      ev_o = EV_NONE;
    else if (n_chg == 1)  ev_o = EV_ONE;
    else                  ev_o = EV_MANY;
  end

  // R6: a change seen this cycle is absorbed into the reference next cycle
  a_r6_change_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg_o != '0) |=> (ref_q == $past(sync_i)));
endmodule

// File: rtl/lci_last_tracker.sv
module lci_last_tracker
  import lci_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] chg_i,
  input  chg_ev_e          ev_i,
  output logic [WIDTH-1:0] last_o
);
  logic [WIDTH-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              last_q <= '0;
    else if (ev_i == EV_ONE)  last_q <= chg_i;
  end

  assign last_o = last_q;

  a_r4_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(last_q));

  a_r5_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_NONE) |=> $stable(last_q));

  a_r6_hold_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_MANY) |=> $stable(last_q));

  // R2 / R3: a lone change selects its own output
  a_r2_single_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == EV_ONE) |=> (last_q == $past(chg_i)));
endmodule

// File: rtl/last_change_ind.sv
module last_change_ind
  import lci_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x1_i,
  input  logic x2_i,
  output logic z1_o,
  output logic z2_o
);
  localparam int NUM_IN = 2;

  logic [NUM_IN-1:0] x_raw, x_sync, chg, last;
  chg_ev_e           ev;

  assign x_raw = {x2_i, x1_i};

  lci_sync #(.WIDTH(NUM_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (x_raw),
    .q_o   (x_sync)
  );

  lci_change_det #(.WIDTH(NUM_IN)) det_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sync_i(x_sync),
    .chg_o (chg),
    .ev_o  (ev)
  );

  lci_last_tracker #(.WIDTH(NUM_IN)) trk_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .chg_i (chg),
    .ev_i  (ev),
    .last_o(last)
  );

  assign z1_o = last[0];
  assign z2_o = last[1];

  a_r4_ports_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(z1_o && z2_o));

  // R3: an x2-only synchronised change raises z2 one cycle later
  a_r3_x2_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chg == 2'b10) |=> (z2_o && !z1_o));
endmodule

// File: tb/last_change_ind_tb_top.sv
`timescale 1ns/1ps
module last_change_ind_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x1 = 1'b0, x2 = 1'b0;
  logic z1, z2;
  int n_chk = 0, n_fail = 0;
  logic [1:0] exp_z = 2'b00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  last_change_ind #(.SYNC_STAGES(2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .x1_i(x1), .x2_i(x2), .z1_o(z1), .z2_o(z2)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: z={%b,%b} expected {%b,%b}", req, act[1], act[0], exp[1], exp[0]);
    end
  endtask

  task automatic check_excl();
    n_chk++;
    if (z1 === 1'b1 && z2 === 1'b1) begin
      n_fail++;
      $display("FAIL R4: z1=%b z2=%b expected at most one high", z1, z2);
    end
  endtask

  task automatic apply(input logic [1:0] v);
    logic [1:0] d;
    string req;
    @(negedge clk);
    d = v ^ {x2, x1};
    {x2, x1} = v;
    repeat (2) @(posedge clk);
    #1 check("R1", {z2, z1}, exp_z);
    if (d == 2'b01 || d == 2'b10) exp_z = d;
    if (d == 2'b01)      req = "R2";
    else if (d == 2'b10) req = "R3";
    else if (d == 2'b11) req = "R6";
    else                 req = "R5";
    @(posedge clk);
    #1 check(req, {z2, z1}, exp_z);
    check_excl();
  endtask

  initial begin
    #1 check("R7", {z2, z1}, 2'b00);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(posedge clk);
      #1 check("R7", {z2, z1}, 2'b00);
    end
    // every transition between every pair of input levels
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        apply(2'(f));
        apply(2'(t));
      end
    end
    apply(2'b00);
    apply(2'b10);
    for (int c = 0; c < 20; c++) begin
      @(posedge clk);
      #1 check("R5", {z2, z1}, exp_z);
    end
    // async clear, then release with x1 already high
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R7", {z2, z1}, 2'b00);
    {x2, x1} = 2'b01;
    exp_z = 2'b00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R7", {z2, z1}, 2'b00);
    @(posedge clk);
    #1 check("R7", {z2, z1}, 2'b01);
    exp_z = 2'b01;
    apply(2'b10);
    apply(2'b11);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule